// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a wide set of external input pins and turns selected activity on them into a single interrupt request. Each pin is a line. Each line has its own sensitivity, which is edge or level, and its own polarity, which is rising/high or falling/low. Each line also has a mask bit, a target-domain enable and a status bit. The pins are asynchronous and pass through a two-flop synchroniser before any detection. Lines are packed 32 to a bank, so line n sits in bank n/32 at bit n%32.

Software reaches the block through a flat write port and a combinational read port. The sensitivity, polarity and mask fields never take a whole-word write. Each has a set alias and a clear alias, so one line can change without a read-modify-write. Status is cleared through a write-one acknowledge alias. The enable field is written as a whole word. The request output is the OR, across all lines, of status that is unmasked and enabled.

Top module: `eint_ctrl`

## Requirements
- R1: An address is {func[3:0], bank[2:0]}, and line n maps to bank n/32, bit n%32. The func codes are: 0 status, 1 acknowledge, 2 mask, 3 mask-set, 4 mask-clear, 5 sensitivity, 6 sensitivity-set, 7 sensitivity-clear, 8 polarity, 9 polarity-set, 10 polarity-clear, 11 enable. Reading an acknowledge or set/clear alias returns the current value of its field.
- R2: After reset every line is masked (mask=1), edge-sensitive (sensitivity=0), falling polarity (polarity=0) and disabled (enable=0), with status clear and irq_o low.
- R3: Writing to a set alias sets each field bit whose data bit is 1. Writing to a clear alias clears each such bit. Bits written as 0 keep their value. This holds for mask, sensitivity and polarity.
- R4: A write to the enable func loads the whole enable word of the addressed bank.
- R5: A pin passes through two synchronising flops. In edge mode with polarity 1, a rising pin sets status; with polarity 0, a falling pin sets it. Status is readable no later than 3 clock cycles after the pin changes, and the opposite edge has no effect.
- R6: In edge mode, status stays set until a 1 is written to its bit of the acknowledge alias; acknowledge bits written as 0 have no effect. If the selected edge is detected in the same cycle as the acknowledge, status remains set.
- R7: In level mode, status follows the active level: the pin is high when polarity is 1 and low when polarity is 0. An acknowledge has no lasting effect while the level is active.
- R8: Status is raised whether or not the line is masked or enabled.
- R9: irq_o is high exactly when some line has status=1, mask=0 and enable=1.
- R10: Bits above the last line, banks 5 to 7 and func codes 12 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 135 | Asynchronous external lines |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write address {func, bank} |
| wr_data | input | 32 | Write data, one bit per line of the bank |
| rd_addr | input | 7 | Read address {func, bank} |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an edge arriving in the very clock cycle that software acknowledges the same line. When that happens the event must not be lost. The bench first makes the line's status sticky with one edge. It then changes the pin and counts the two synchroniser stages, so that the acknowledge write lands on the exact cycle the detector fires. A control run without the edge shows that the same acknowledge does clear the bit. A fixed-seed random mix of pin flips and alias writes then keeps lines moving between edge and level modes and polarities. After each step the bench compares every field and irq_o against a bench model.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int WORD_W = 32;
    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        F_STAT     = 4'd0,
        F_ACK      = 4'd1,
        F_MASK     = 4'd2,
        F_MASK_SET = 4'd3,
        F_MASK_CLR = 4'd4,
        F_SENS     = 4'd5,
        F_SENS_SET = 4'd6,
        F_SENS_CLR = 4'd7,
        F_POL      = 4'd8,
        F_POL_SET  = 4'd9,
        F_POL_CLR  = 4'd10,
        F_EN       = 4'd11
    } func_e;

    // One-hot write strobes handed to a bank
    typedef struct packed {
        logic ack;
        logic mset;
        logic mclr;
        logic sset;
        logic sclr;
        logic pset;
        logic pclr;
        logic enw;
    } bank_wr_t;

    function automatic int bank_count(input int lines);
        return (lines + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int bank_width(input int lines, input int b);
        int rem;
        rem = lines - b * WORD_W;
        return (rem < WORD_W) ? rem : WORD_W;
    endfunction

    function automatic bank_wr_t decode_wr(input logic hit, input logic [FUNC_W-1:0] f);
        bank_wr_t s;
        s = '0;
        if (hit) begin
            case (func_e'(f))
                F_ACK:      s.ack  = 1'b1;
                F_MASK_SET: s.mset = 1'b1;
                F_MASK_CLR: s.mclr = 1'b1;
                F_SENS_SET: s.sset = 1'b1;
                F_SENS_CLR: s.sclr = 1'b1;
                F_POL_SET:  s.pset = 1'b1;
                F_POL_CLR:  s.pclr = 1'b1;
                F_EN:       s.enw  = 1'b1;
                default:    s      = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eint_bank.sv
module eint_bank
    import eint_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_s,
    input  bank_wr_t     wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] sens_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] en_q,
    output logic         irq
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] active;
    logic [W-1:0] ackv;
    logic [W-1:0] stat_d;

    // Edge detect on synchronised pins; polarity picks the edge
    assign hit    = (pin_s & ~prev_q & pol_q) | (~pin_s & prev_q & ~pol_q);
    assign active = ~(pin_s ^ pol_q);
    assign ackv   = wr.ack ? wdata : '0;
    // New edge wins over a same-cycle acknowledge
    assign stat_d = (sens_q & active) | (~sens_q & (hit | (stat_q & ~ackv)));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
            mask_q <= '1;
            sens_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else begin
            prev_q <= pin_s;
            stat_q <= stat_d;
            if (wr.mset) mask_q <= mask_q | wdata;
            if (wr.mclr) mask_q <= mask_q & ~wdata;
            if (wr.sset) sens_q <= sens_q | wdata;
            if (wr.sclr) sens_q <= sens_q & ~wdata;
            if (wr.pset) pol_q  <= pol_q | wdata;
            if (wr.pclr) pol_q  <= pol_q & ~wdata;
            if (wr.enw)  en_q   <= wdata;
        end
    end

    assign irq = |(stat_q & ~mask_q & en_q);

    p_ack_clears_edge_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(ackv & ~sens_q & ~hit)) == '0));

    p_edge_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q & ~sens_q & ~ackv) & ~stat_q) == '0));

    p_level_ack_noeffect_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~stat_q & $past(sens_q & ~(pin_s ^ pol_q))) == '0));

    p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
        wr.mset |=> ((mask_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 135,
    parameter int BANK_AW   = 3,
    parameter int SYNC_STG  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_LINES-1:0]      pin_i,
    input  logic                      wr_en,
    input  logic [FUNC_W+BANK_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [FUNC_W+BANK_AW-1:0] rd_addr,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      irq_o
);
    localparam int NUM_BANKS = bank_count(NUM_LINES);
    localparam int PAD_W     = NUM_BANKS * WORD_W;

    logic [NUM_LINES-1:0] pin_s;
    logic [PAD_W-1:0]     stat_pad, mask_pad, sens_pad, pol_pad, en_pad;
    logic [NUM_BANKS-1:0] bank_irq;
    logic [FUNC_W-1:0]    wr_func, rd_func;
    logic [BANK_AW-1:0]   wr_bank, rd_bank;

    assign wr_func = wr_addr[FUNC_W+BANK_AW-1:BANK_AW];
    assign wr_bank = wr_addr[BANK_AW-1:0];
    assign rd_func = rd_addr[FUNC_W+BANK_AW-1:BANK_AW];
    assign rd_bank = rd_addr[BANK_AW-1:0];

    eint_sync #(.W(NUM_LINES), .STAGES(SYNC_STG)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_s)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int LO = b * WORD_W;
            localparam int BW = bank_width(NUM_LINES, b);
            bank_wr_t wr_b;

            assign wr_b = decode_wr(wr_en && (wr_bank == BANK_AW'(b)), wr_func);

            eint_bank #(.W(BW)) i_bank (
                .clk    (clk),
                .rst    (rst),
                .pin_s  (pin_s[LO +: BW]),
                .wr     (wr_b),
                .wdata  (wr_data[BW-1:0]),
                .stat_q (stat_pad[LO +: BW]),
                .mask_q (mask_pad[LO +: BW]),
                .sens_q (sens_pad[LO +: BW]),
                .pol_q  (pol_pad[LO +: BW]),
                .en_q   (en_pad[LO +: BW]),
                .irq    (bank_irq[b])
            );
        end

        if (PAD_W > NUM_LINES) begin : g_pad
            assign stat_pad[PAD_W-1:NUM_LINES] = '0;
            assign mask_pad[PAD_W-1:NUM_LINES] = '0;
            assign sens_pad[PAD_W-1:NUM_LINES] = '0;
            assign pol_pad[PAD_W-1:NUM_LINES]  = '0;
            assign en_pad[PAD_W-1:NUM_LINES]   = '0;
        end
    endgenerate

    assign irq_o = |bank_irq;

    always_comb begin
        rd_data = '0;
        if (int'(rd_bank) < NUM_BANKS) begin
            case (func_e'(rd_func))
                F_STAT, F_ACK:                  rd_data = stat_pad[int'(rd_bank)*WORD_W +: WORD_W];
                F_MASK, F_MASK_SET, F_MASK_CLR: rd_data = mask_pad[int'(rd_bank)*WORD_W +: WORD_W];
                F_SENS, F_SENS_SET, F_SENS_CLR: rd_data = sens_pad[int'(rd_bank)*WORD_W +: WORD_W];
                F_POL, F_POL_SET, F_POL_CLR:    rd_data = pol_pad[int'(rd_bank)*WORD_W +: WORD_W];
                F_EN:                           rd_data = en_pad[int'(rd_bank)*WORD_W +: WORD_W];
                default:                        rd_data = '0;
            endcase
        end
    end

    p_irq_needs_path_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((en_pad != '0) && (stat_pad != '0) && (mask_pad != {PAD_W{1'b1}})));
endmodule

// File: tb/test_eint_ctrl.sv
`timescale 1ns/1ps
module test_eint_ctrl;
    localparam int NL = 135;
    localparam int NB = 5;
    localparam int PB = 160;
    localparam logic [PB-1:0] VALID = {{(PB-NL){1'b0}}, {NL{1'b1}}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] pin_i = '0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [6:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [PB-1:0] m_stat, m_mask, m_sens, m_pol, m_en, m_pin;

    always #2 clk = ~clk;

    eint_ctrl i_eint_ctrl (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [PB-1:0] v, input int b);
        return (b < NB) ? v[b*32 +: 32] : 32'h0;
    endfunction

    function automatic logic [31:0] rd(input int f, input int b);
        return 32'h0;
    endfunction

    task automatic read_chk(input string req, input int f, input int b, input logic [31:0] exp);
        rd_addr = {4'(f), 3'(b)};
        #0.05;
        chk(req, rd_data, exp);
    endtask

    function automatic void m_level();
        m_stat = (m_stat & ~m_sens) | (m_sens & ~(m_pin ^ m_pol) & VALID);
    endfunction

    function automatic void m_write(input int f, input int b, input logic [31:0] d);
        logic [PB-1:0] v;
        logic [PB-1:0] wm;
        v  = (b < NB) ? ((PB'(d) << (b*32)) & VALID) : '0;
        wm = (b < NB) ? (PB'(32'hFFFF_FFFF) << (b*32)) : '0;
        case (f)
            1:  m_stat = m_stat & ~(v & ~m_sens);
            3:  m_mask = m_mask | v;
            4:  m_mask = m_mask & ~v;
            6:  m_sens = m_sens | v;
            7:  m_sens = m_sens & ~v;
            9:  m_pol  = m_pol | v;
            10: m_pol  = m_pol & ~v;
            11: m_en   = (m_en & ~wm) | v;
            default: ;
        endcase
        m_level();
    endfunction

    function automatic void m_pins(input logic [PB-1:0] np);
        logic [PB-1:0] hit;
        hit    = ((np & ~m_pin & m_pol) | (~np & m_pin & ~m_pol)) & VALID;
        m_stat = m_stat | (hit & ~m_sens);
        m_pin  = np & VALID;
        m_level();
    endfunction

    function automatic logic m_irq();
        return |(m_stat & ~m_mask & m_en);
    endfunction

    // Called at a negedge; bus active for exactly the next posedge
    task automatic bus_wr(input int f, input int b, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = {4'(f), 3'(b)}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_wr(input int f, input int b, input logic [31:0] d);
        bus_wr(f, b, d);
        m_write(f, b, d);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_pins(input logic [PB-1:0] np);
        pin_i = np[NL-1:0];
        m_pins(np);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all();
        for (int b = 0; b < NB; b++) begin
            read_chk("R5/R6/R7 status", 0, b, word_of(m_stat, b));
            read_chk("R3 mask", 2, b, word_of(m_mask, b));
            read_chk("R3 sens", 5, b, word_of(m_sens, b));
            read_chk("R3 pol", 8, b, word_of(m_pol, b));
            read_chk("R4 enable", 11, b, word_of(m_en, b));
        end
        chk("R9 irq", {31'b0, irq_o}, {31'b0, m_irq()});
    endtask

    function automatic logic [PB-1:0] line(input int n);
        return PB'(1) << n;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_stat = '0; m_mask = VALID; m_sens = '0; m_pol = '0; m_en = '0; m_pin = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        read_chk("R2 mask reset", 2, 0, 32'hFFFF_FFFF);
        read_chk("R2 stat reset", 0, 3, 32'h0);
        read_chk("R10 mask top bits", 2, 4, 32'h0000_007F);
        chk("R2 irq reset", {31'b0, irq_o}, 32'h0);
        check_all();

        // R1 mapping: line 70 is bank 2 bit 6, rising edge, unmasked, enabled
        do_wr(4, 2, 32'h40);
        do_wr(11, 2, 32'h40);
        do_wr(9, 2, 32'h40);
        read_chk("R1 alias readback", 9, 2, 32'h40);
        do_pins(line(70));
        read_chk("R1 status bank2 bit6", 0, 2, 32'h40);
        read_chk("R5 rising edge", 1, 2, 32'h40);
        chk("R9 irq line 70", {31'b0, irq_o}, 32'h1);
        check_all();

        // R6 sticky across falling pin and zero-bit ack
        do_pins('0);
        read_chk("R6 sticky after fall", 0, 2, 32'h40);
        do_wr(1, 2, 32'hFFFF_FFBF);
        read_chk("R6 zero ack bit", 0, 2, 32'h40);
        do_wr(1, 2, 32'h40);
        read_chk("R6 ack clears", 0, 2, 32'h0);
        chk("R9 irq cleared", {31'b0, irq_o}, 32'h0);

        // R6 collision: set sticky, then edge detected on the ack cycle
        do_pins(line(70));
        do_pins('0);
        pin_i = line(70)[NL-1:0];
        @(negedge clk);
        @(negedge clk);
        bus_wr(1, 2, 32'h40);
        m_write(1, 2, 32'h40);
        m_pins(line(70));
        repeat (3) @(negedge clk);
        read_chk("R6 edge beats ack", 0, 2, 32'h40);
        do_wr(1, 2, 32'h40);
        read_chk("R6 control ack clears", 0, 2, 32'h0);
        check_all();

        // R7 level-high on line 3
        do_wr(6, 0, 32'h8);
        do_wr(9, 0, 32'h8);
        do_pins(line(70) | line(3));
        read_chk("R7 level high active", 0, 0, 32'h8);
        do_wr(1, 0, 32'h8);
        read_chk("R7 ack no effect", 0, 0, 32'h8);
        do_pins(line(70));
        read_chk("R7 level drops", 0, 0, 32'h0);
        do_wr(10, 0, 32'h8);
        read_chk("R7 level low active", 0, 0, 32'h8);
        check_all();

        // R8 masked line 100 (bank 3 bit 4), falling edge default
        do_pins(line(70) | line(100));
        do_pins(line(70));
        read_chk("R8 masked status", 0, 3, 32'h10);
        chk("R8 irq unaffected", {31'b0, irq_o}, {31'b0, m_irq()});

        // R10 undefined space
        read_chk("R10 func 12", 12, 0, 32'h0);
        read_chk("R10 bank 5", 11, 5, 32'h0);
        do_wr(11, 6, 32'hFFFF_FFFF);
        do_wr(3, 7, 32'hFFFF_FFFF);
        do_wr(11, 4, 32'hFFFF_FFFF);
        read_chk("R10 top enable bits", 11, 4, 32'h0000_007F);
        check_all();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [PB-1:0] flip;
                for (int w = 0; w < NB; w++)
                    flip[w*32 +: 32] = $urandom() & $urandom() & $urandom();
                do_pins((m_pin ^ flip) & VALID);
            end else begin
                int fsel [8] = '{1, 3, 4, 6, 7, 9, 10, 11};
                int f = fsel[$urandom_range(0, 7)];
                int b = ($urandom_range(0, 9) == 0) ? $urandom_range(5, 7) : $urandom_range(0, NB-1);
                do_wr(f, b, $urandom() & $urandom());
            end
            check_all();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule